// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two 64-bit IEEE-754 double-precision operands and folds the outcome into an integer condition-code word. The caller presents both operands together with the current flags word and a valid strobe. One clock later the block returns the flags word with six arithmetic flags rewritten and every other bit carried through unchanged.

The outcome is one of four relations: unordered, less, equal or greater. Each relation is encoded on a fixed set of three flags. The other three arithmetic flags are always forced low. The comparison needs no floating-point library. It detects NaNs from the exponent and mantissa fields, treats both signed zeros as equal, and orders infinities and subnormals by their sign and magnitude.

Top module: `fpcmp_flag_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted operation, valid_o is 0 and flags_o is all zeros.
- R2: An operation presented with valid_i=1 produces valid_o=1 and the updated flags_o exactly one clock later. In a cycle with valid_i=0, flags_o keeps its previous value on the next cycle and valid_o is 0.
- R3: If either operand is a NaN, the result is unordered and sets bit 6 (zero flag), bit 2 (parity flag) and bit 0 (carry flag). This takes priority over every ordering check. A NaN has an all-ones exponent and a nonzero mantissa. Quiet and signaling NaNs of either sign are treated the same.
- R4: When operand A is less than operand B, bit 0 is 1 and bits 6 and 2 are 0.
- R5: When operand A is greater than operand B, bits 6, 2 and 0 are all 0.
- R6: When the operands are equal, bit 6 is 1 and bits 2 and 0 are 0. Positive zero and negative zero are equal to each other.
- R7: Bit 11 (overflow), bit 7 (sign) and bit 4 (auxiliary carry) of flags_o are always 0 after an operation.
- R8: Every flags_o bit other than bits 0, 2, 4, 6, 7 and 11 equals the same bit of the flags_i word that was accepted.
- R9: Non-NaN values are ordered by sign and magnitude:
  - a negative value is below a positive one, unless both are zero;
  - with both operands negative, the larger magnitude is the lesser value;
  - infinities lie beyond the largest finite magnitude;
  - subnormals lie above zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and flags word are valid this cycle |
| op_a_i | input | 64 | Operand A, double precision |
| op_b_i | input | 64 | Operand B, double precision |
| flags_i | input | 32 | Current condition-code word |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| flags_o | output | 32 | Updated condition-code word |

## Verification
Two functions can apply in the same cycle: NaN detection and the sign-magnitude ordering. A NaN operand also has a sign bit and a magnitude that would otherwise rank it against the other operand. The bench provokes this with a negative NaN against negative infinity, where the ordering alone would report "less". It also pairs a NaN with an ordinary value on each side. Each case is judged by requiring the unordered encoding, with zero, parity and carry all set, and never the ordered one. The flag merge and the pass-through of unrelated bits are judged in the same cycle against several distinct incoming flags words.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int unsigned FP_EXP_W = 11;
  localparam int unsigned FP_MAN_W = 52;

  // condition-code positions decoded by downstream branch logic
  localparam int unsigned CF_POS = 0;
  localparam int unsigned PF_POS = 2;
  localparam int unsigned AF_POS = 4;
  localparam int unsigned ZF_POS = 6;
  localparam int unsigned SF_POS = 7;
  localparam int unsigned OF_POS = 11;

  typedef enum logic [1:0] {
    REL_GT    = 2'd0,
    REL_LT    = 2'd1,
    REL_EQ    = 2'd2,
    REL_UNORD = 2'd3
  } rel_e;

  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_zero;
    logic sign;
  } fp_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W = FP_EXP_W,
  parameter int unsigned MAN_W = FP_MAN_W,
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] op_i,
  output fp_class_t         cls_o,
  output logic [MAG_W-1:0]  mag_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             man_nz;

  assign exp_f   = op_i[DATA_W-2 -: EXP_W];
  assign man_f   = op_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls_o.is_nan  = exp_max & man_nz;
    cls_o.is_inf  = exp_max & ~man_nz;
    cls_o.is_zero = ~|op_i[MAG_W-1:0];
    cls_o.sign    = op_i[DATA_W-1];
  end

  assign mag_o = op_i[MAG_W-1:0];

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int unsigned MAG_W = FP_EXP_W + FP_MAN_W
) (
  input  fp_class_t        cls_a_i,
  input  fp_class_t        cls_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output rel_e             rel_o
);

  logic mag_lt;
  logic mag_gt;
  logic both_zero;
  logic a_less;
  logic a_equal;

  assign mag_lt    = mag_a_i < mag_b_i;
  assign mag_gt    = mag_a_i > mag_b_i;
  assign both_zero = cls_a_i.is_zero & cls_b_i.is_zero;

  always_comb begin
    a_less  = 1'b0;
    a_equal = 1'b0;
    if (both_zero) begin
      a_equal = 1'b1;
    end else if (cls_a_i.sign != cls_b_i.sign) begin
      a_less = cls_a_i.sign;
    end else if (cls_a_i.sign) begin
      a_less  = mag_gt;
      a_equal = ~mag_gt & ~mag_lt;
    end else begin
      a_less  = mag_lt;
      a_equal = ~mag_gt & ~mag_lt;
    end
  end

  // unordered first, then less, then equal
  always_comb begin
    if (cls_a_i.is_nan || cls_b_i.is_nan) rel_o = REL_UNORD;
    else if (a_less)                      rel_o = REL_LT;
    else if (a_equal)                     rel_o = REL_EQ;
    else                                  rel_o = REL_GT;
  end

endmodule

// File: rtl/fpcmp_flag_merge.sv
module fpcmp_flag_merge
  import fpcmp_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  rel_e              rel_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);

  localparam logic [FLAG_W-1:0] ONE = FLAG_W'(1);
  localparam logic [FLAG_W-1:0] CLR_MASK =
    (ONE << CF_POS) | (ONE << PF_POS) | (ONE << AF_POS) |
    (ONE << ZF_POS) | (ONE << SF_POS) | (ONE << OF_POS);

  logic zf_v;
  logic pf_v;
  logic cf_v;

  always_comb begin
    unique case (rel_i)
      REL_UNORD: {zf_v, pf_v, cf_v} = 3'b111;
      REL_LT:    {zf_v, pf_v, cf_v} = 3'b001;
      REL_EQ:    {zf_v, pf_v, cf_v} = 3'b100;
      default:   {zf_v, pf_v, cf_v} = 3'b000;
    endcase
  end

  always_comb begin
    flags_o         = flags_i & ~CLR_MASK;
    flags_o[ZF_POS] = zf_v;
    flags_o[PF_POS] = pf_v;
    flags_o[CF_POS] = cf_v;
  end

endmodule

// File: rtl/fpcmp_flag_gen.sv
module fpcmp_flag_gen
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned MAN_W  = FP_MAN_W,
  parameter int unsigned FLAG_W = 32,
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W,
  localparam int unsigned MAG_W  = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam logic [FLAG_W-1:0] ONE = FLAG_W'(1);
  localparam logic [FLAG_W-1:0] OWN_MASK =
    (ONE << CF_POS) | (ONE << PF_POS) | (ONE << AF_POS) |
    (ONE << ZF_POS) | (ONE << SF_POS) | (ONE << OF_POS);

  logic [DATA_W-1:0] ops [2];
  fp_class_t         cls [2];
  logic [MAG_W-1:0]  mag [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .op_i (ops[g]),
      .cls_o(cls[g]),
      .mag_o(mag[g])
    );
  end

  rel_e              rel;
  logic [FLAG_W-1:0] flags_nxt;

  fpcmp_order #(
    .MAG_W(MAG_W)
  ) u_order (
    .cls_a_i(cls[0]),
    .cls_b_i(cls[1]),
    .mag_a_i(mag[0]),
    .mag_b_i(mag[1]),
    .rel_o  (rel)
  );

  fpcmp_flag_merge #(
    .FLAG_W(FLAG_W)
  ) u_merge (
    .rel_i  (rel),
    .flags_i(flags_i),
    .flags_o(flags_nxt)
  );

  logic              valid_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) flags_q <= flags_nxt;
    end
  end

  assign valid_o = valid_q;
  assign flags_o = flags_q;

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(flags_o) && !valid_o)); // R2
  AST_NAN_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (cls[0].is_nan || cls[1].is_nan)) |=>
      (flags_o[ZF_POS] && flags_o[PF_POS] && flags_o[CF_POS])); // R3
  AST_ZERO_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls[0].is_zero && cls[1].is_zero) |=>
      (flags_o[ZF_POS] && !flags_o[PF_POS] && !flags_o[CF_POS])); // R6
  AST_ARITH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_o[OF_POS] || flags_o[SF_POS] || flags_o[AF_POS])); // R7
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (((flags_o ^ $past(flags_i)) & ~OWN_MASK) == '0)); // R8
  AST_SIGN_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cls[0].is_nan && !cls[1].is_nan &&
     cls[0].sign && !cls[1].sign && !(cls[0].is_zero && cls[1].is_zero)) |=>
      (flags_o[CF_POS] && !flags_o[ZF_POS])); // R9

endmodule

// File: tb/fpcmp_flag_gen_tb_top.sv
module fpcmp_flag_gen_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] NNAN = 64'hFFF8000000000000;
  localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] NMAX = 64'hFFEFFFFFFFFFFFFF;
  localparam logic [63:0] PDEN = 64'h0000000000000001;

  // relation codes in the table: 0 greater, 1 less, 2 equal, 3 unordered
  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] fin;
    logic [1:0]  rel;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{P1,   P2,   32'hFFFFFFFF, 2'd1},
    '{P2,   P1,   32'h00000000, 2'd0},
    '{P1,   P1,   32'hA5A5A5A5, 2'd2},
    '{N1,   N2,   32'h12345678, 2'd0},
    '{N2,   N1,   32'hFFFFFFFF, 2'd1},
    '{N1,   P1,   32'h0000F0F0, 2'd1},
    '{P1,   N1,   32'hFFFFFFFF, 2'd0},
    '{PZ,   NZ,   32'h00000000, 2'd2},
    '{NZ,   PZ,   32'hFFFFFFFF, 2'd2},
    '{QNAN, P1,   32'h5A5A5A5A, 2'd3},
    '{P1,   SNAN, 32'h00000000, 2'd3},
    '{NNAN, NINF, 32'hFFFFFFFF, 2'd3},
    '{PINF, PMAX, 32'h0F0F0F0F, 2'd0},
    '{NINF, NMAX, 32'hFFFFFFFF, 2'd1},
    '{PDEN, PZ,   32'h00000001, 2'd0},
    '{NZ,   PDEN, 32'hFFFFFFFF, 2'd1},
    '{PINF, PINF, 32'h80000000, 2'd2},
    '{QNAN, QNAN, 32'hFFFFFFFF, 2'd3},
    '{NINF, PINF, 32'h00000800, 2'd1},
    '{N1,   NNAN, 32'h00000000, 2'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic [31:0] flags_i = '0;
  logic        valid_o;
  logic [31:0] flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpcmp_flag_gen dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .flags_i(flags_i),
    .valid_o(valid_o),
    .flags_o(flags_o)
  );

  function automatic logic [31:0] expect_flags(logic [31:0] fin, logic [1:0] rel);
    logic [31:0] r;
    r = fin;
    r[0] = 1'b0; r[2] = 1'b0; r[4] = 1'b0;
    r[6] = 1'b0; r[7] = 1'b0; r[11] = 1'b0;
    case (rel)
      2'd3: begin r[6] = 1'b1; r[2] = 1'b1; r[0] = 1'b1; end
      2'd1: r[0] = 1'b1;
      2'd2: r[6] = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic string rel_req(logic [1:0] rel);
    case (rel)
      2'd3: return "R3";
      2'd1: return "R4";
      2'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    check("R1 flags in reset", flags_o, 32'd0);
    rst_ni = 1'b1;
    op_a_i = P1; op_b_i = P2; flags_i = 32'hFFFFFFFF;
    repeat (2) @(negedge clk_i);
    check("R1 idle after reset", {31'd0, valid_o}, 32'd0);
    check("R1 flags after reset", flags_o, 32'd0);

    // table walk; R7 and R8 folded into every expected word, R9 via signed rows
    for (int i = 0; i < NV; i++) begin
      op_a_i  = VEC[i].a;
      op_b_i  = VEC[i].b;
      flags_i = VEC[i].fin;
      valid_i = 1'b1;
      @(negedge clk_i);
      check("R2 valid latency", {31'd0, valid_o}, 32'd1);
      check({rel_req(VEC[i].rel), " R7 R8 R9"}, flags_o,
            expect_flags(VEC[i].fin, VEC[i].rel));
    end

    // R2: idle cycles hold the last result
    valid_i = 1'b0;
    op_a_i  = P1; op_b_i = P2; flags_i = 32'h00000000;
    @(negedge clk_i);
    check("R2 valid drops", {31'd0, valid_o}, 32'd0);
    check("R2 hold", flags_o, expect_flags(32'h00000000, 2'd3));
    op_a_i = QNAN; flags_i = 32'hFFFFFFFF;
    @(negedge clk_i);
    check("R2 hold after input change", flags_o, expect_flags(32'h00000000, 2'd3));

    // R3 priority: NaN on B whose sign/magnitude would rank it greater
    op_a_i = NMAX; op_b_i = 64'h7FFFFFFFFFFFFFFF; flags_i = 32'h0000FFFF;
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R3 NaN over ordering", flags_o, expect_flags(32'h0000FFFF, 2'd3));

    // R6 negative zeros both sides, R7 with all arithmetic bits set on input
    op_a_i = NZ; op_b_i = NZ; flags_i = 32'h000008D5;
    @(negedge clk_i);
    check("R6 R7 neg zero pair", flags_o, expect_flags(32'h000008D5, 2'd2));

    // R9 negative subnormal below negative zero
    op_a_i = 64'h8000000000000001; op_b_i = NZ; flags_i = 32'hDEADBEEF;
    @(negedge clk_i);
    check("R9 neg subnormal", flags_o, expect_flags(32'hDEADBEEF, 2'd1));
    valid_i = 1'b0;

    // R1: reset mid-stream clears
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 re-reset flags", flags_o, 32'd0);
    check("R1 re-reset valid", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end

endmodule